// File: doc/BRIEF.md
# Mailbox Interrupt Flag Controller

This block sits beside a two-port shared memory and produces one interrupt flag for each port. The two highest word addresses of the memory serve as mailboxes. The top address belongs to the right side and the address just below it belongs to the left side. When one port writes into the other side's mailbox, that other side's flag goes low. The flag returns high when its owner reads its own mailbox.

The mailbox words remain ordinary memory that the array stores. This block only watches the access strobes and never touches data. A port whose collision indicator (busy, active low) is asserted cannot raise its peer's flag. Clearing is not gated by busy.

All strobes are active low and are sampled on the rising clock edge. Each flag is a registered push-pull output that changes on the edge where the triggering access is sampled.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: While reset is low, and on the first edge after it, both `l_irq_n` and `r_irq_n` are high (deasserted).
- R2: If the right port is sampled with `r_sel_n`=0, `r_wr_n`=0, `r_busy_n`=1 and `r_addr` equal to the left mailbox (all ones minus one, 0x1FFE at ADDR_W=13), then `l_irq_n` is 0 after that edge.
- R3: If the left port is sampled with `l_sel_n`=0, `l_oe_n`=0 and `l_addr` equal to the left mailbox, then `l_irq_n` is 1 after that edge, whatever the value of `l_wr_n`, unless R6 applies.
- R4: The right flag mirrors R2 and R3. A left write (`l_sel_n`=0, `l_wr_n`=0, `l_busy_n`=1) to the right mailbox (all ones, 0x1FFF) drives `r_irq_n` to 0. A right access with `r_sel_n`=0 and `r_oe_n`=0 to that mailbox drives it back to 1.
- R5: A write whose busy input is 0 does not set the peer's flag.
- R6: If a set and a clear of the same flag are sampled on the same edge, the flag ends up asserted (0).
- R7: Accesses that do not match exactly have no effect on either flag. This covers other addresses, a deselected port, a read without output enable, a write by a port into its own mailbox, and a read by a port of its peer's mailbox.
- R8: The mailbox addresses follow ADDR_W. At ADDR_W=12 they are 0xFFE (left) and 0xFFF (right).
- R9: With no set and no clear event, each flag holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| l_sel_n | input | 1 | Left port select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_wr_n | input | 1 | Left write strobe, active low |
| l_busy_n | input | 1 | Left collision indicator, active low; blocks left writes |
| l_addr | input | ADDR_W | Left word address |
| r_sel_n | input | 1 | Right port select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_wr_n | input | 1 | Right write strobe, active low |
| r_busy_n | input | 1 | Right collision indicator, active low; blocks right writes |
| r_addr | input | ADDR_W | Right word address |
| l_irq_n | output | 1 | Left interrupt flag, active low |
| r_irq_n | output | 1 | Right interrupt flag, active low |

## Verification
The only internal state is the two flag registers. A flag that is stuck or corrupted shows up on the interrupt pin one edge after the access that should have moved it. A wrong address decode appears either as a missed message or as an interrupt that is raised or cleared without cause, and both are visible on the next cycle. The bench keeps a reference model of both flags for the default width and for a 12-bit instance. It compares them against every edge, so a lost set, a lost clear, a wrong priority or a leak through busy is reported in the cycle where it happens.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // Mailbox address for a given address width: right owns the top word,
  // left owns the word just below it.
  function automatic int unsigned box_addr(input int unsigned aw, input bit right_side);
    return (32'd1 << aw) - (right_side ? 32'd1 : 32'd2);
  endfunction

  // Flag register next state: set dominates clear (flag is active high inside).
  function automatic logic flag_next(input logic cur, input logic set, input logic clr);
    return set ? 1'b1 : (clr ? 1'b0 : cur);
  endfunction
endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
  parameter int unsigned ADDR_W = 13,
  parameter logic [ADDR_W-1:0] OWN_BOX = '1,
  parameter logic [ADDR_W-1:0] PEER_BOX = '1
) (
  input  logic              sel_n,
  input  logic              oe_n,
  input  logic              wr_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              post_o,  // unblocked write into peer mailbox
  output logic              take_o   // read of own mailbox
);
  logic sel;
  assign sel    = ~sel_n;
  assign post_o = sel & ~wr_n & busy_n & (addr == PEER_BOX);
  assign take_o = sel & ~oe_n & (addr == OWN_BOX);
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_n_o
);
  logic flag_q;
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= mbox_pkg::flag_next(flag_q, set_i, clr_i);
  end
  assign flag_n_o = ~flag_q;
endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl #(
  parameter int unsigned ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sel_n,
  input  logic              l_oe_n,
  input  logic              l_wr_n,
  input  logic              l_busy_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel_n,
  input  logic              r_oe_n,
  input  logic              r_wr_n,
  input  logic              r_busy_n,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  localparam logic [ADDR_W-1:0] L_BOX = ADDR_W'(mbox_pkg::box_addr(ADDR_W, 1'b0));
  localparam logic [ADDR_W-1:0] R_BOX = ADDR_W'(mbox_pkg::box_addr(ADDR_W, 1'b1));

  // Named events for the checker
  logic l_post, l_take, r_post, r_take;

  mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(L_BOX), .PEER_BOX(R_BOX)) u_dec_l (
    .sel_n(l_sel_n), .oe_n(l_oe_n), .wr_n(l_wr_n), .busy_n(l_busy_n), .addr(l_addr),
    .post_o(l_post), .take_o(l_take)
  );

  mbox_port_decode #(.ADDR_W(ADDR_W), .OWN_BOX(R_BOX), .PEER_BOX(L_BOX)) u_dec_r (
    .sel_n(r_sel_n), .oe_n(r_oe_n), .wr_n(r_wr_n), .busy_n(r_busy_n), .addr(r_addr),
    .post_o(r_post), .take_o(r_take)
  );

  // Left flag: set by right post, cleared by left take
  mbox_flag u_flag_l (.clk(clk), .rst_n(rst_n), .set_i(r_post), .clr_i(l_take), .flag_n_o(l_irq_n));
  // Right flag: set by left post, cleared by right take
  mbox_flag u_flag_r (.clk(clk), .rst_n(rst_n), .set_i(l_post), .clr_i(r_take), .flag_n_o(r_irq_n));
endmodule

// File: rtl/mbox_irq_checker.sv
module mbox_irq_checker (
  input logic clk,
  input logic rst_n,
  input logic l_post,
  input logic l_take,
  input logic r_post,
  input logic r_take,
  input logic l_busy_n,
  input logic r_busy_n,
  input logic l_irq_n,
  input logic r_irq_n
);
  assert_reset_idle_R1: assert property (@(posedge clk) !rst_n |=> (l_irq_n && r_irq_n));

  assert_left_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    r_post |=> !l_irq_n);

  assert_left_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (l_take && !r_post) |=> l_irq_n);

  assert_right_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    l_post |=> !r_irq_n);

  assert_right_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (r_take && !l_post) |=> r_irq_n);

  assert_busy_blocks_left_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && l_irq_n) |=> l_irq_n);

  assert_busy_blocks_right_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_busy_n && r_irq_n) |=> r_irq_n);

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (r_post && l_take) |=> !l_irq_n);

  assert_left_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_post && !l_take) |=> $stable(l_irq_n));

  assert_right_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_post && !r_take) |=> $stable(r_irq_n));
endmodule

bind mbox_irq_ctrl mbox_irq_checker u_chk (
  .clk(clk), .rst_n(rst_n),
  .l_post(l_post), .l_take(l_take), .r_post(r_post), .r_take(r_take),
  .l_busy_n(l_busy_n), .r_busy_n(r_busy_n),
  .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
);

// File: tb/mbox_irq_ctrl_bench.sv
module mbox_irq_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic l_sel_n = 1, l_oe_n = 1, l_wr_n = 1, l_busy_n = 1;
  logic r_sel_n = 1, r_oe_n = 1, r_wr_n = 1, r_busy_n = 1;
  logic [12:0] l_addr = '0, r_addr = '0;
  logic wl_n, wr_n_o, nl_n, nr_n;

  mbox_irq_ctrl u_mbox_irq_ctrl (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_busy_n(l_busy_n), .l_addr(l_addr),
    .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_busy_n(r_busy_n), .r_addr(r_addr),
    .l_irq_n(wl_n), .r_irq_n(wr_n_o)
  );

  // Narrow instance (R8): sees the low 12 address bits
  mbox_irq_ctrl #(.ADDR_W(12)) u_mbox_irq_ctrl_narrow (
    .clk(clk), .rst_n(rst_n),
    .l_sel_n(l_sel_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_busy_n(l_busy_n), .l_addr(l_addr[11:0]),
    .r_sel_n(r_sel_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_busy_n(r_busy_n), .r_addr(r_addr[11:0]),
    .l_irq_n(nl_n), .r_irq_n(nr_n)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Scoreboard: expected {wide L, wide R, narrow L, narrow R}
  logic [3:0] exp_q[$];
  string      tag_q[$];

  // Reference model state (1 = deasserted)
  logic m_wl = 1, m_wr = 1, m_nl = 1, m_nr = 1;

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: flags {wideL,wideR,narrowL,narrowR} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Model one flag of one width: left mailbox = top-1, right mailbox = top
  function automatic logic upd(input logic cur, input bit set, input bit clr);
    if (set) return 1'b0;
    if (clr) return 1'b1;
    return cur;
  endfunction

  task automatic apply(input logic ls, lo, lw, lb, input logic [12:0] la,
                       input logic rs, ro, rw, rb, input logic [12:0] ra,
                       input string tag);
    bit rwrite, lwrite, lread, rread;
    @(negedge clk);
    l_sel_n = ls; l_oe_n = lo; l_wr_n = lw; l_busy_n = lb; l_addr = la;
    r_sel_n = rs; r_oe_n = ro; r_wr_n = rw; r_busy_n = rb; r_addr = ra;
    rwrite = !rs && !rw && rb;
    lwrite = !ls && !lw && lb;
    lread  = !ls && !lo;
    rread  = !rs && !ro;
    m_wl = upd(m_wl, rwrite && ra == 13'h1FFE, lread && la == 13'h1FFE);
    m_wr = upd(m_wr, lwrite && la == 13'h1FFF, rread && ra == 13'h1FFF);
    m_nl = upd(m_nl, rwrite && ra[11:0] == 12'hFFE, lread && la[11:0] == 12'hFFE);
    m_nr = upd(m_nr, lwrite && la[11:0] == 12'hFFF, rread && ra[11:0] == 12'hFFF);
    exp_q.push_back({m_wl, m_wr, m_nl, m_nr});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    apply(1,1,1,1,13'h0, 1,1,1,1,13'h0, tag);
  endtask

  // Monitor: compare 5 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        logic [3:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({wl_n, wr_n_o, nl_n, nr_n}, e, t);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check({wl_n, wr_n_o, nl_n, nr_n}, 4'b1111, "R1 during reset");
    rst_n = 1'b1;
    idle("R1 first edge after reset");
    idle("R9 idle hold");
    // R2: right writes left mailbox
    apply(1,1,1,1,13'h0, 0,1,0,1,13'h1FFE, "R2 right write sets left flag");
    idle("R9 left flag holds set");
    // R3: left read clears, write strobe also low
    apply(0,0,0,1,13'h1FFE, 1,1,1,1,13'h0, "R3 left access clears, wr ignored");
    // R5: blocked write
    apply(1,1,1,1,13'h0, 0,1,0,0,13'h1FFE, "R5 busy blocks left set");
    apply(0,1,0,0,13'h1FFF, 1,1,1,1,13'h0, "R5 busy blocks right set");
    // R4: right flag set and clear
    apply(0,1,0,1,13'h1FFF, 1,1,1,1,13'h0, "R4 left write sets right flag");
    idle("R9 right flag holds");
    apply(1,1,1,1,13'h0, 0,0,1,1,13'h1FFF, "R4 right read clears right flag");
    // R6: set and clear on the same edge
    apply(0,0,1,1,13'h1FFE, 0,1,0,1,13'h1FFE, "R6 set wins over clear (left)");
    apply(0,0,1,1,13'h1FFE, 1,1,1,1,13'h0, "R3 later clear");
    apply(0,1,0,1,13'h1FFF, 0,0,1,1,13'h1FFF, "R6 set wins over clear (right)");
    apply(1,1,1,1,13'h0, 0,0,1,1,13'h1FFF, "R4 later clear");
    // R8: 0xFFE matters only at 12 bits
    apply(1,1,1,1,13'h0, 0,1,0,1,13'h0FFE, "R8 narrow left mailbox 0xFFE");
    apply(0,1,0,1,13'h0FFF, 1,1,1,1,13'h0, "R8 narrow right mailbox 0xFFF");
    apply(0,0,1,1,13'h0FFE, 0,0,1,1,13'h0FFF, "R8 narrow clears");
    // R7: non-matching accesses
    apply(1,1,1,1,13'h0, 0,1,0,1,13'h1FFE, "R7 setup: set left flag");
    apply(0,1,0,1,13'h1FFE, 0,0,1,1,13'h1FFE, "R7 own-box write and peer-box read ignored");
    apply(0,1,1,1,13'h1FFE, 1,1,1,1,13'h0, "R7 select without oe no clear");
    apply(1,0,1,1,13'h1FFE, 1,1,1,1,13'h0, "R7 oe while deselected no clear");
    apply(1,1,0,1,13'h1FFF, 1,1,0,1,13'h1FFE, "R7 write while deselected no set");
    apply(0,1,0,1,13'h1FFD, 0,1,0,1,13'h1FFD, "R7 other address no set");
    apply(0,0,1,1,13'h1FFE, 1,1,1,1,13'h0, "R3 final clear");
    idle("R9 final idle");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule